// File: doc/BRIEF.md
# Low-Power Wakeup Interrupt Framer

This block runs from the slow time-base clock while the device sleeps. It divides that clock into repeating interrupt frames whose length is picked by a 2-bit select, and it marks the last clock of each frame with a one-cycle strobe. Ten event sources feed it: one external interrupt line, eight wakeup lines and the timer overflow pulse. Each source has its own sticky pending flag. The interrupt request is the OR of those flags.

The line inputs are asynchronous and active low. Each one passes through a synchronizer, and only a falling edge counts. While the device is in a low-power state and no wake transition is in progress, an edge is staged so that it lands in its pending flag at the end of the second strobe after it is recognised. A timer overflow lands at the next strobe. This places every new request on a strobe instant, and it keeps the wake latency between one and two frames. During the transition back to full speed, and whenever the low-power flag is low, staging is bypassed. Events already waiting are released at once, and new events land one clock after recognition. Software clears pending flags with a write-one-to-clear mask.

Top module: `wake_frame_irq`

## Requirements
- R1: `strobe` is high for exactly one clock at the end of each frame. A frame lasts 2^(BASE_LOG + STEP_LOG*k) clocks for frame_sel code k = 0, 1, 2. The defaults give 1024, 4096 and 16384 clocks.
- R2: frame_sel code 3 gives the same frame length as code 2.
- R3: a line input passes through two synchronizing flops, and only a high-to-low transition is an event. Rising edges and steady levels never set a pending flag.
- R4: pending bit 0 belongs to `ext_int_n`, bit 1+j belongs to `wake_n[j]`, and bit N_WAKE+1 belongs to the timer. In aligned mode (`lowpwr`=1 and `wake_xfer`=0), a recognised edge sets its bit at the clock edge that ends the second strobe after recognition. A strobe that coincides with recognition does not count.
- R5: in aligned mode with a fixed select, the delay from a falling input to its pending bit lies between T+4 and 2T+3 clocks, where T is the frame length.
- R6: in aligned mode, a `tmr_ovf` pulse sets the timer bit at the end of the next strobe. The delay is 2 to T+1 clocks from driving the pulse.
- R7: in aligned mode, `irq` rises only in the clock that follows a strobe.
- R8: when not aligned, a recognised edge or a timer pulse sets its bit on the next clock edge, which is 3 clocks after a line falls. Events that are still waiting for a strobe are set on the first clock of non-aligned mode.
- R9: a pending bit stays set until a clock with `clr_we`=1 and the matching `clr_mask` bit at 1. A set in the same clock wins over the clear. `clr_mask` has no effect while `clr_we`=0.
- R10: `irq` is the OR of all pending bits.
- R11: a low `rst_n` clears the pending bits, `irq` and `strobe` at once. After release, the block restarts its frame two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | slow time-base clock |
| rst_n | input | 1 | asynchronous active-low reset |
| frame_sel | input | 2 | frame length select |
| ext_int_n | input | 1 | external interrupt line, falling edge active |
| wake_n | input | N_WAKE | wakeup lines, falling edge active |
| tmr_ovf | input | 1 | timer overflow pulse, synchronous |
| lowpwr | input | 1 | device is in a low-power state |
| wake_xfer | input | 1 | transition to full speed in progress |
| clr_we | input | 1 | clear enable for pending flags |
| clr_mask | input | N_WAKE+2 | write-one-to-clear mask |
| strobe | output | 1 | end-of-frame strobe |
| pend | output | N_WAKE+2 | pending flags |
| irq | output | 1 | interrupt request |

## Verification
The hardest case to reach is an edge that is still waiting in staging when the wake transition begins. It has to be recognised after one strobe has already passed, and the transition has to arrive before the next strobe. The stimulus first waits for a strobe on the output. It then drops a wakeup line at once, lets the synchronizer settle for a few clocks, and raises `wake_xfer` well before the frame ends. The pending flag must appear on the following clock. A randomized phase also toggles `lowpwr` and `wake_xfer` at arbitrary frame positions, and a cycle-level model checks every output on every clock.

// File: rtl/wfi_pkg.sv
package wfi_pkg;

  // log2 of the frame length for a select code; code 3 folds onto code 2
  function automatic int unsigned frame_log(input logic [1:0] sel,
                                            input int unsigned base,
                                            input int unsigned step);
    int unsigned k;
    k = (sel == 2'd3) ? 2 : int'(sel);
    return base + step * k;
  endfunction

endpackage

// File: rtl/wfi_frame_timer.sv
module wfi_frame_timer #(
  parameter int unsigned BASE_LOG = 10,
  parameter int unsigned STEP_LOG = 2
) (
  input  logic       clk_slow,
  input  logic       rst_n,
  input  logic [1:0] frame_sel,
  output logic       strobe
);
  import wfi_pkg::*;

  localparam int unsigned CW = BASE_LOG + 2 * STEP_LOG;

  logic [CW-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last   = CW'((64'd1 << frame_log(frame_sel, BASE_LOG, STEP_LOG)) - 64'd1);
    strobe = (cnt_q >= last);
    cnt_d  = strobe ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_STROBE_PULSE: assert property (@(posedge clk_slow) disable iff (!rst_n)
    strobe |=> !strobe); // R1
  AST_FRAME_RESTART: assert property (@(posedge clk_slow) disable iff (!rst_n)
    strobe |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/wfi_edge_sync.sv
module wfi_edge_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk_slow,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, pv_q;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      pv_q <= '1;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      pv_q <= s2_q;
    end
  end

  assign fall = pv_q & ~s2_q;

  AST_FALL_ONLY: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (fall == (fall & ~s2_q))); // R3

endmodule

// File: rtl/wfi_stage.sv
module wfi_stage #(
  parameter int unsigned HOPS = 2
) (
  input  logic clk_slow,
  input  logic rst_n,
  input  logic ev,
  input  logic strobe,
  input  logic aligned,
  output logic set
);
  logic [HOPS-1:0] stg_q, stg_d, shifted;

  generate
    if (HOPS == 1) begin : g_one
      assign shifted = ev;
    end else begin : g_many
      assign shifted = {stg_q[HOPS-2:0], ev};
    end
  endgenerate

  always_comb begin
    stg_d = stg_q;
    set   = 1'b0;
    if (!aligned) begin
      set   = ev | (|stg_q);
      stg_d = '0;
    end else if (strobe) begin
      set   = stg_q[HOPS-1];
      stg_d = shifted;
    end else begin
      stg_d[0] = stg_q[0] | ev;
    end
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  AST_STAGE_DRAIN: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !aligned |=> (stg_q == '0)); // R8

endmodule

// File: rtl/wake_frame_irq.sv
module wake_frame_irq #(
  parameter int unsigned N_WAKE   = 8,
  parameter int unsigned BASE_LOG = 10,
  parameter int unsigned STEP_LOG = 2
) (
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic [1:0]        frame_sel,
  input  logic              ext_int_n,
  input  logic [N_WAKE-1:0] wake_n,
  input  logic              tmr_ovf,
  input  logic              lowpwr,
  input  logic              wake_xfer,
  input  logic              clr_we,
  input  logic [N_WAKE+1:0] clr_mask,
  output logic              strobe,
  output logic [N_WAKE+1:0] pend,
  output logic              irq
);
  localparam int unsigned NE = N_WAKE + 1;
  localparam int unsigned NS = N_WAKE + 2;
  localparam int unsigned TB = NS - 1;

  logic          rs1_q, rs2_q, rst_i;
  logic          aligned;
  logic [NE-1:0] fall;
  logic [NS-1:0] set_v, pend_q, pend_d, clr_v;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i   = rs2_q;
  assign aligned = lowpwr & ~wake_xfer;

  wfi_frame_timer #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG)) u_timer (
    .clk_slow (clk_slow),
    .rst_n    (rst_i),
    .frame_sel(frame_sel),
    .strobe   (strobe)
  );

  wfi_edge_sync #(.W(NE)) u_sync (
    .clk_slow(clk_slow),
    .rst_n   (rst_i),
    .din     ({wake_n, ext_int_n}),
    .fall    (fall)
  );

  for (genvar i = 0; i < NS; i++) begin : g_src
    if (i == TB) begin : g_tmr
      wfi_stage #(.HOPS(1)) u_stage (
        .clk_slow(clk_slow), .rst_n(rst_i), .ev(tmr_ovf),
        .strobe(strobe), .aligned(aligned), .set(set_v[i])
      );
    end else begin : g_line
      wfi_stage #(.HOPS(2)) u_stage (
        .clk_slow(clk_slow), .rst_n(rst_i), .ev(fall[i]),
        .strobe(strobe), .aligned(aligned), .set(set_v[i])
      );
    end
  end

  always_comb begin
    clr_v  = clr_we ? clr_mask : '0;
    pend_d = (pend_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk_slow or negedge rst_i) begin
    if (!rst_i) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign irq  = |pend_q;

  AST_IRQ_ON_STROBE: assert property (@(posedge clk_slow) disable iff (!rst_i)
    ($rose(irq) && $past(aligned)) |-> $past(strobe)); // R7
  AST_PEND_STICKY: assert property (@(posedge clk_slow) disable iff (!rst_i)
    !clr_we |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R9

endmodule

// File: tb/test_wake_frame_irq.sv
`timescale 1ns/1ps
module test_wake_frame_irq;
  localparam int NW = 8;
  localparam int BL = 4;
  localparam int SL = 1;
  localparam int NSRC = NW + 2;

  logic clk = 1'b0;
  logic rst_n, ext_int_n, tmr_ovf, lowpwr, wake_xfer, clr_we;
  logic [1:0] frame_sel;
  logic [NW-1:0] wake_n;
  logic [NSRC-1:0] clr_mask;
  logic strobe, irq;
  logic [NSRC-1:0] pend;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wake_frame_irq #(.N_WAKE(NW), .BASE_LOG(BL), .STEP_LOG(SL)) i_wake_frame_irq (
    .clk_slow(clk), .rst_n(rst_n), .frame_sel(frame_sel), .ext_int_n(ext_int_n),
    .wake_n(wake_n), .tmr_ovf(tmr_ovf), .lowpwr(lowpwr), .wake_xfer(wake_xfer),
    .clr_we(clr_we), .clr_mask(clr_mask), .strobe(strobe), .pend(pend), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int got, input int lo, input int hi);
    total++;
    if (got < lo || got > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, got, lo, hi);
    end
  endtask

  function automatic int flen(input logic [1:0] s);
    int k;
    k = (s == 2'd3) ? 2 : int'(s);
    return 1 << (BL + SL * k);
  endfunction

  // behavioural reference model
  int m_rs, m_cnt;
  int n1 [NW+1];
  int n2 [NW+1];
  bit tq;
  logic [NW:0] ms1, ms2, mpv;
  logic [NSRC-1:0] m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_cnt = 0; tq = 0; m_pend = '0;
      ms1 = '1; ms2 = '1; mpv = '1;
      for (int i = 0; i <= NW; i++) begin n1[i] = 0; n2[i] = 0; end
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      bit stb, al;
      logic [NW:0] ev;
      logic [NSRC-1:0] st, cl;
      stb = (m_cnt >= flen(frame_sel) - 1);
      al  = lowpwr && !wake_xfer;
      ev  = mpv & ~ms2;
      st  = '0;
      for (int i = 0; i <= NW; i++) begin
        if (al) begin
          if (stb) begin
            if (n1[i] > 0) st[i] = 1'b1;
            n1[i] = n2[i];
            n2[i] = ev[i] ? 1 : 0;
          end else if (ev[i]) n2[i]++;
        end else begin
          if (ev[i] || n1[i] > 0 || n2[i] > 0) st[i] = 1'b1;
          n1[i] = 0; n2[i] = 0;
        end
      end
      if (al) begin
        if (stb) begin st[NSRC-1] = tq; tq = tmr_ovf; end
        else tq = tq | tmr_ovf;
      end else begin
        st[NSRC-1] = tmr_ovf | tq; tq = 0;
      end
      cl = clr_we ? clr_mask : '0;
      m_pend = (m_pend & ~cl) | st;
      mpv = ms2; ms2 = ms1; ms1 = {wake_n, ext_int_n};
      m_cnt = stb ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    chk("R1 strobe vs model", strobe, (m_cnt >= flen(frame_sel) - 1));
    chk("R4 pend vs model", pend, m_pend);
    chk("R10 irq vs model", irq, |m_pend);
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic look(); @(negedge clk); endtask

  task automatic period(output int p);
    p = 0;
    do look(); while (!strobe);
    do begin look(); p++; end while (!strobe && p < 500);
  endtask

  task automatic clear_all();
    tick(); clr_we = 1'b1; clr_mask = '1; tick(); clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, lat;
    bit got, prev;
    rst_n = 0; frame_sel = 0; ext_int_n = 1; wake_n = '1; tmr_ovf = 0;
    lowpwr = 1; wake_xfer = 0; clr_we = 0; clr_mask = '0;
    repeat (3) tick();
    look();
    chk("R11 reset pend", pend, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset strobe", strobe, 0);
    tick(); rst_n = 1;

    period(p); chk("R1 period sel0", p, 16);
    tick(); frame_sel = 1; period(p); period(p); chk("R1 period sel1", p, 32);
    tick(); frame_sel = 2; period(p); period(p); chk("R1 period sel2", p, 64);
    tick(); frame_sel = 3; period(p); period(p); chk("R2 period sel3", p, 64);
    tick(); frame_sel = 0; period(p);

    // R4 / R5 / R7: aligned edge latency on wake_n[3]
    tick(); wake_n[3] = 1'b0; lat = 0; got = 0; prev = 0;
    for (int c = 0; c < 200 && !got; c++) begin
      @(posedge clk); lat++; look();
      if (pend[4]) got = 1; else prev = strobe;
    end
    chk_rng("R5 edge latency", lat, 20, 35);
    chk("R4 bit map", pend, 10'h010);
    chk("R7 rise after strobe", prev, 1);
    chk("R10 irq set", irq, 1);

    // R9: mask without enable, then real clear
    tick(); clr_mask = '1; tick(); clr_mask = '0; look();
    chk("R9 mask ignored", pend, 10'h010);
    tick(); clr_we = 1; clr_mask = 10'h010; tick(); clr_we = 0; clr_mask = '0; look();
    chk("R9 cleared", pend, 0);
    chk("R10 irq clear", irq, 0);

    // R3: rising edge does nothing
    tick(); wake_n[3] = 1'b1; repeat (60) tick(); look();
    chk("R3 rise ignored", pend, 0);

    // R6: timer overflow
    tick(); tmr_ovf = 1; tick(); tmr_ovf = 0; lat = 1; got = 0;
    look(); if (pend[NSRC-1]) got = 1;
    for (int c = 0; c < 100 && !got; c++) begin
      @(posedge clk); lat++; look(); if (pend[NSRC-1]) got = 1;
    end
    chk_rng("R6 timer latency", lat, 2, 17);
    chk("R6 timer bit", pend, 10'h200);
    clear_all();

    // R8: non-aligned immediate
    tick(); lowpwr = 0; wake_n[0] = 0; lat = 0; got = 0;
    for (int c = 0; c < 20 && !got; c++) begin
      @(posedge clk); lat++; look(); if (pend[1]) got = 1;
    end
    chk("R8 direct latency", lat, 3);
    tick(); wake_n[0] = 1; lowpwr = 1; clear_all();

    // R8: staged edge released by wake transition
    do look(); while (!strobe);
    tick(); wake_n[5] = 0;
    repeat (5) tick(); look();
    chk("R8 still staged", pend[6], 0);
    tick(); wake_xfer = 1; tick(); look();
    chk("R8 released", pend[6], 1);
    tick(); wake_xfer = 0; wake_n[5] = 1; clear_all();

    // mixed random phase, model compared every clock
    for (int c = 0; c < 3000; c++) begin
      tick();
      if ($urandom_range(0, 9) == 0) wake_n[$urandom_range(0, NW-1)] ^= 1'b1;
      if ($urandom_range(0, 19) == 0) ext_int_n ^= 1'b1;
      tmr_ovf = ($urandom_range(0, 49) == 0);
      if ($urandom_range(0, 99) == 0) lowpwr ^= 1'b1;
      wake_xfer = ($urandom_range(0, 29) == 0);
      clr_we = ($urandom_range(0, 14) == 0);
      clr_mask = NSRC'($urandom());
    end
    tick(); clr_we = 0; tmr_ovf = 0; wake_xfer = 0;

    // R11: reset in mid-run
    rst_n = 0; look();
    chk("R11 async pend", pend, 0);
    chk("R11 async irq", irq, 0);
    chk("R11 async strobe", strobe, 0);
    tick(); rst_n = 1; repeat (5) tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule